// File: doc/BRIEF.md
# I2S Stereo to Dual-Mono Splitter

This block takes an I2S stereo stream with 32 bit clocks per channel slot and turns it into two separate serial outputs, one for each mono converter. The left output carries the left sample in both halves of its frame and the right output carries the right sample in both halves. Each converter therefore sees a full stereo frame that holds one channel twice. It can feed a balanced pair of inputs inside one converter.

The serial data runs through a 64-stage delay line with a tap after stage 32. For each output bit the block picks the live input bit, the 32-cycle copy or the 64-cycle copy, depending on the input word select. An optional mode sends the second copy of each sample bit-inverted, so the converter's two halves can be driven as a differential pair. Plain inversion is used, which is off by one LSB from true negation. An active-low mute forces both data outputs low.

All state changes on the rising edge of `clk`. Every output register samples the tap values present just before the edge on which the delay line shifts. The bit clock sent to the converters is `clk` inverted, so output data changes on the edge the converters do not sample.

Top module: `i2s_mono_split`

## Requirements
- R1: After each rising `clk` edge, `ws_l` and `ws_r` both equal the inverse of the `ws_in` value sampled at that edge.
- R2: `bclk_out` is always the logical inverse of `clk`.
- R3: When `ws_in` is 1 at an edge and `mute_n` is 1, after that edge `sd_r` equals the `sd_in` sampled at that edge and `sd_l` equals the `sd_in` sampled 32 edges earlier.
- R4: When `ws_in` is 0 at an edge and `mute_n` and `same_pol` are 1, after that edge `sd_r` equals the `sd_in` sampled 32 edges earlier and `sd_l` equals the `sd_in` sampled 64 edges earlier.
- R5: When `ws_in` is 0 and `same_pol` is 0 (differential mode) and `mute_n` is 1, the outputs are the R4 values. They are inverted if `ws_in` was 0 at the previous edge and unchanged if it was 1.
- R6: When `mute_n` is 0 at an edge, both `sd_l` and `sd_r` are 0 after that edge, whatever the other inputs are.
- R7: A synchronous `rst` clears all outputs except `bclk_out`, the delay line and the delayed word select. After release, every delayed copy that reaches back before the reset reads as 0. The delayed word select reads as 0 on the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input bit clock; all registers use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ws_in | input | 1 | Input word select, 1 during the right slot |
| sd_in | input | 1 | Input serial data |
| same_pol | input | 1 | 1: both copies sent as is; 0: second copy inverted |
| mute_n | input | 1 | Active-low mute of both data outputs |
| bclk_out | output | 1 | Bit clock to both converters, inverse of `clk` |
| ws_l | output | 1 | Word select to the left-channel converter |
| sd_l | output | 1 | Serial data to the left-channel converter |
| ws_r | output | 1 | Word select to the right-channel converter |
| sd_r | output | 1 | Serial data to the right-channel converter |

## Verification
Mute and the differential inversion can both apply to the same bit. When the selected tap holds 0 and inversion would turn it into 1, only the mute decides the output. The bench releases and reasserts mute partway through frames while differential mode is on. The cycles right after a word-select edge are judged against a model that tracks the delayed word select separately. A reference model built from the recorded input history predicts every output bit, including zero fill after a reset taken in the middle of a stream.

// File: rtl/i2s_mono_split.sv
module i2s_mono_split #(
  parameter int SLOT_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic ws_in,
  input  logic sd_in,
  input  logic same_pol,
  input  logic mute_n,
  output logic bclk_out,
  output logic ws_l,
  output logic sd_l,
  output logic ws_r,
  output logic sd_r
);
  localparam int LINE = 2 * SLOT_BITS;

  logic [LINE-1:0] line_q;
  logic            ws_dly_q;
  logic            tap_mid, tap_end, flip, nxt_r, nxt_l;

  assign tap_mid  = line_q[SLOT_BITS-1];
  assign tap_end  = line_q[LINE-1];
  assign flip     = ~same_pol & ~ws_dly_q;
  assign nxt_r    = ws_in ? sd_in   : (tap_mid ^ flip);
  assign nxt_l    = ws_in ? tap_mid : (tap_end ^ flip);
  assign bclk_out = ~clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= '0;
      ws_dly_q <= 1'b0;
      ws_l     <= 1'b0;
      ws_r     <= 1'b0;
      sd_l     <= 1'b0;
      sd_r     <= 1'b0;
    end else begin
      line_q   <= {line_q[LINE-2:0], sd_in};
      ws_dly_q <= ws_in;
      ws_l     <= ~ws_in;
      ws_r     <= ~ws_in;
      sd_l     <= mute_n & nxt_l;
      sd_r     <= mute_n & nxt_r;
    end
  end
endmodule

// File: rtl/split_chk.sv
module split_chk (
  input logic clk,
  input logic rst,
  input logic ws_in,
  input logic sd_in,
  input logic same_pol,
  input logic mute_n,
  input logic tap_mid,
  input logic ws_l,
  input logic ws_r,
  input logic sd_l,
  input logic sd_r
);
  AST_WS_MIRROR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ws_l == !$past(ws_in)) && (ws_r == !$past(ws_in))); // R1

  AST_MUTE_LOW: assert property (@(posedge clk) disable iff (rst)
    !mute_n |=> !sd_l && !sd_r); // R6

  AST_LIVE_RIGHT: assert property (@(posedge clk) disable iff (rst)
    ws_in && mute_n |=> sd_r == $past(sd_in)); // R3

  AST_MID_RIGHT: assert property (@(posedge clk) disable iff (rst)
    !ws_in && same_pol && mute_n |=> sd_r == $past(tap_mid)); // R4
endmodule

bind i2s_mono_split split_chk u_chk (
  .clk(clk), .rst(rst), .ws_in(ws_in), .sd_in(sd_in), .same_pol(same_pol),
  .mute_n(mute_n), .tap_mid(tap_mid), .ws_l(ws_l), .ws_r(ws_r),
  .sd_l(sd_l), .sd_r(sd_r)
);

// File: tb/sim_i2s_mono_split.sv
`timescale 1ns/1ps
module sim_i2s_mono_split;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ws_in = 1'b0, sd_in = 1'b0, same_pol = 1'b1, mute_n = 1'b1;
  logic bclk_out, ws_l, sd_l, ws_r, sd_r;

  i2s_mono_split u0 (
    .clk(clk), .rst(rst), .ws_in(ws_in), .sd_in(sd_in), .same_pol(same_pol),
    .mute_n(mute_n), .bclk_out(bclk_out), .ws_l(ws_l), .sd_l(sd_l),
    .ws_r(ws_r), .sd_r(sd_r)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0, n = 0, pos = 0;
  bit done = 0;
  bit hs [0:8191];
  bit hw [0:8191];
  logic [15:0] lfsr = 16'hACE1;

  // {same_pol, mute_n, seed}
  localparam logic [17:0] VEC [6] = '{
    {1'b1, 1'b1, 16'hACE1}, {1'b0, 1'b1, 16'h1234}, {1'b1, 1'b1, 16'hFFFF},
    {1'b0, 1'b1, 16'h8001}, {1'b0, 1'b0, 16'h5A5A}, {1'b1, 1'b0, 16'h0F0F}
  };

  function automatic bit hget(int idx);
    return (idx >= 0) ? hs[idx] : 1'b0;
  endfunction

  task automatic check(string req, logic act, logic exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: cycle %0d actual %b expected %b", req, n, act, exp_v);
    end
  endtask

  task automatic step(logic ws_v, logic sd_v);
    bit wsd, fl, er, el, mt, sp;
    string tag;
    ws_in = ws_v; sd_in = sd_v;
    mt = mute_n; sp = same_pol;
    @(posedge clk);
    hs[n] = sd_v; hw[n] = ws_v;
    wsd = (n >= 1) ? hw[n-1] : 1'b0;
    fl = !sp && !wsd;
    if (ws_v) begin
      er = sd_v; el = hget(n - 32); tag = "R3";
    end else begin
      er = hget(n - 32) ^ fl; el = hget(n - 64) ^ fl;
      tag = sp ? "R4" : "R5";
    end
    if (!ws_v && n < 64) tag = "R7";
    if (!mt) begin er = 0; el = 0; tag = "R6"; end
    #1;
    check("R2", bclk_out, 1'b0);
    @(negedge clk);
    check("R2", bclk_out, 1'b1);
    check("R1", ws_l, !ws_v);
    check("R1", ws_r, !ws_v);
    check(tag, sd_r, er);
    check(tag, sd_l, el);
    n++;
  endtask

  task automatic stream_bit();
    logic b;
    b = lfsr[0];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    step(pos >= 32, b);
    pos = (pos + 1) % 64;
  endtask

  task automatic do_reset(int k);
    rst = 1'b1;
    for (int i = 0; i < k; i++) @(posedge clk);
    @(negedge clk);
    check("R7", ws_l, 1'b0);
    check("R7", ws_r, 1'b0);
    check("R7", sd_l, 1'b0);
    check("R7", sd_r, 1'b0);
    rst = 1'b0;
    n = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset(3);
    for (int v = 0; v < 6; v++) begin
      same_pol = VEC[v][17];
      mute_n   = VEC[v][16];
      lfsr     = VEC[v][15:0];
      for (int c = 0; c < 192; c++) stream_bit();
    end
    // R6 with R5: mute toggled mid-slot while differential mode is on
    same_pol = 1'b0; lfsr = 16'h3C3C;
    for (int c = 0; c < 256; c++) begin
      mute_n = !((c % 64) >= 20 && (c % 64) < 45);
      stream_bit();
    end
    // R7: reset mid-stream, then all-ones input; taps must read zero
    mute_n = 1'b1; same_pol = 1'b1;
    do_reset(2);
    pos = 0;
    for (int c = 0; c < 128; c++) begin
      step(pos >= 32, 1'b1);
      pos = (pos + 1) % 64;
    end
    // R5: differential mode right after reset, word select edges
    same_pol = 1'b0;
    do_reset(1);
    pos = 0;
    for (int c = 0; c < 128; c++) begin
      step(pos >= 32, c[0]);
      pos = (pos + 1) % 64;
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule